// File: doc/BRIEF.md
# Programming-Port Access Gate with Security Latch

This block sits between an external programming port and the on-chip storage of a small controller. The storage is a program memory, reached through a request/acknowledge handshake, plus a one-byte option register and an eight-byte user area, both held inside the block. Each request names a target, a direction, an address and a write byte. The block decides whether the request is allowed, carries it out, and returns a one-cycle completion strobe with read data and an error flag. A fourth target code is an erase command for the program memory.

Bit 5 of the option byte is a security latch. Once it is set, program-memory reads return all ones without touching the array. Writes to the program memory and to the option byte are refused. The option byte stays readable and the user area stays fully usable. No request can clear the latch, and an erase keeps it. The block also decodes the latched option byte into the clock-source mode, the watchdog enable and the halt enable for the rest of the chip.

Top module: `prog_access_gate`

## Requirements
- R1: After reset the block reports ready, done and error are low, and the option byte holds OPT_RST (default 0x00). With that value the oscillator mode is 0, the watchdog is enabled, the halt mode is enabled and security is off.
- R2: Targets are encoded as req_target 0 = program memory, 1 = option byte, 2 = user area, 3 = erase. An unsecured program read or write holds mem_req with a stable address until mem_ack. resp_done rises in the cycle after the edge that samples mem_ack. A read returns the array byte, and never-written bytes read 0x00.
- R3: While secured, a program read completes in the cycle after acceptance with data 0xFF and no error, and it raises no mem_req.
- R4: While secured, a write to the program memory or to the option byte is refused. It completes in the cycle after acceptance with resp_err high for that one cycle only, and it leaves memory and option byte unchanged.
- R5: An option-byte read returns the latched byte whether or not security is set.
- R6: The eight user bytes, selected by req_addr[2:0], can be read and written in any security state.
- R7: Security (option bit 5) cannot be cleared. An erase clears the whole program memory to 0x00 and clears every option bit except bit 5, which it keeps.
- R8: cfg_osc_mode equals option bits [4:3]: 0 external, 1 R/C, 2 crystal without bias resistor, 3 crystal with bias resistor.
- R9: cfg_wdog_en is the inverse of option bit 2, and cfg_halt_en is the inverse of option bit 0.
- R10: The configuration outputs change only after a successful option write or an erase. They take the new value in the same cycle that the completion strobe rises.
- R11: Option-byte, user-area and refused requests complete in the cycle after acceptance. Write requests return read data 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 2 | Target code (see R2) |
| req_addr | input | AW | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request is taken at the next edge |
| resp_done | output | 1 | One-cycle completion strobe |
| resp_err | output | 1 | Request refused (with resp_done) |
| resp_rdata | output | 8 | Read data, valid with resp_done |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory write |
| mem_erase | output | 1 | Memory erase command |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| cfg_osc_mode | output | 2 | Decoded clock-source mode |
| cfg_wdog_en | output | 1 | Watchdog enable |
| cfg_halt_en | output | 1 | Halt mode enable |
| cfg_secure | output | 1 | Security latch state |

## Verification
Requests that stay inside the block (option, user, secured reads, refusals) are due one edge after acceptance. A memory request is due two edges plus the responder's programmed wait after acceptance, because the responder registers its acknowledge and the block registers its completion. For each request the bench computes that edge count from its own model. It then compares done, error and mem_req at the falling edge of every cycle up to the due cycle, and compares read data and configuration outputs at the due cycle. Mem_req must be low at every cycle of a local request, so a secured read that reaches the array is caught cycle by cycle.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEC_BIT  = 5;
  localparam int OSC_HI   = 4;
  localparam int OSC_LO   = 3;
  localparam int WDOG_BIT = 2;
  localparam int HALT_BIT = 0;

  typedef enum logic [1:0] {
    TGT_PROG  = 2'd0,
    TGT_OPT   = 2'd1,
    TGT_USER  = 2'd2,
    TGT_ERASE = 2'd3
  } tgt_e;

  function automatic logic [1:0] osc_of(input logic [BYTE_W-1:0] o);
    return o[OSC_HI:OSC_LO];
  endfunction

  function automatic logic wdog_of(input logic [BYTE_W-1:0] o);
    return ~o[WDOG_BIT];
  endfunction

  function automatic logic halt_of(input logic [BYTE_W-1:0] o);
    return ~o[HALT_BIT];
  endfunction

  function automatic logic secure_of(input logic [BYTE_W-1:0] o);
    return o[SEC_BIT];
  endfunction

  // erase keeps only the security latch
  function automatic logic [BYTE_W-1:0] erase_keep(input logic [BYTE_W-1:0] o);
    logic [BYTE_W-1:0] m;
    m = '0;
    m[SEC_BIT] = 1'b1;
    return o & m;
  endfunction
endpackage

// File: rtl/pgate_opt.sv
module pgate_opt
  import pgate_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OPT_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              erase,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] opt_q,
  output logic [1:0]        osc_mode,
  output logic              wdog_en,
  output logic              halt_en,
  output logic              secure
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     opt_q <= OPT_RST;
    else if (erase) opt_q <= erase_keep(opt_q);
    else if (load)  opt_q <= wdata;
  end

  assign osc_mode = osc_of(opt_q);
  assign wdog_en  = wdog_of(opt_q);
  assign halt_en  = halt_of(opt_q);
  assign secure   = secure_of(opt_q);
endmodule

// File: rtl/pgate_user.sv
module pgate_user
  import pgate_pkg::*;
#(
  parameter int NBYTES = 8,
  localparam int UAW   = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [UAW-1:0]    addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] cells [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cells[g] <= '0;
      else if (we && addr == UAW'(g))         cells[g] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_target,
  input  logic [AW-1:0]     req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              secure,
  input  logic [BYTE_W-1:0] opt_q,
  input  logic [BYTE_W-1:0] user_rdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              req_ready,
  output logic              resp_done,
  output logic              resp_err,
  output logic [BYTE_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_erase,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              opt_load,
  output logic              erase_commit,
  output logic              user_we,
  output logic              sec_rd_hit,
  output logic              refused
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e st;

  logic accept, is_prog, is_opt, is_user, is_erase, go_mem, mem_fin, local_done;
  logic [BYTE_W-1:0] local_rd;

  assign req_ready    = (st == S_IDLE);
  assign accept       = req_valid && req_ready;
  assign is_prog      = (tgt_e'(req_target) == TGT_PROG);
  assign is_opt       = (tgt_e'(req_target) == TGT_OPT);
  assign is_user      = (tgt_e'(req_target) == TGT_USER);
  assign is_erase     = (tgt_e'(req_target) == TGT_ERASE);

  assign sec_rd_hit   = accept && is_prog && !req_write && secure;
  assign refused      = accept && req_write && secure && (is_prog || is_opt);
  assign opt_load     = accept && is_opt && req_write && !secure;
  assign user_we      = accept && is_user && req_write;
  assign go_mem       = accept && ((is_prog && !secure) || is_erase);
  assign local_done   = accept && !go_mem;
  assign mem_fin      = (st == S_WAIT) && mem_ack;
  assign erase_commit = mem_fin && mem_erase;

  always_comb begin
    local_rd = '0;
    if (!req_write) begin
      if (sec_rd_hit)   local_rd = '1;
      else if (is_opt)  local_rd = opt_q;
      else if (is_user) local_rd = user_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_erase  <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      resp_done  <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_done <= local_done || mem_fin;
      resp_err  <= refused;
      if (local_done)                          resp_rdata <= local_rd;
      else if (mem_fin && !mem_we && !mem_erase) resp_rdata <= mem_rdata;
      else                                     resp_rdata <= '0;
      if (go_mem) begin
        st        <= S_WAIT;
        mem_req   <= 1'b1;
        mem_we    <= req_write && is_prog;
        mem_erase <= is_erase;
        mem_addr  <= req_addr;
        mem_wdata <= req_wdata;
      end else if (mem_fin) begin
        st        <= S_IDLE;
        mem_req   <= 1'b0;
        mem_we    <= 1'b0;
        mem_erase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prog_access_gate.sv
module prog_access_gate
  import pgate_pkg::*;
#(
  parameter int                AW      = 10,
  parameter int                NUSER   = 8,
  parameter logic [BYTE_W-1:0] OPT_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_target,
  input  logic [AW-1:0]     req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_done,
  output logic              resp_err,
  output logic [BYTE_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_erase,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [1:0]        cfg_osc_mode,
  output logic              cfg_wdog_en,
  output logic              cfg_halt_en,
  output logic              cfg_secure
);
  localparam int UAW = $clog2(NUSER);

  logic [BYTE_W-1:0] opt_q, user_rdata;
  logic opt_load, erase_commit, user_we, sec_rd_hit, refused;

  pgate_opt #(.OPT_RST(OPT_RST)) u_opt (
    .clk(clk), .rst_n(rst_n), .load(opt_load), .erase(erase_commit),
    .wdata(req_wdata), .opt_q(opt_q), .osc_mode(cfg_osc_mode),
    .wdog_en(cfg_wdog_en), .halt_en(cfg_halt_en), .secure(cfg_secure)
  );

  pgate_user #(.NBYTES(NUSER)) u_user (
    .clk(clk), .rst_n(rst_n), .we(user_we), .addr(req_addr[UAW-1:0]),
    .wdata(req_wdata), .rdata(user_rdata)
  );

  pgate_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
    .secure(cfg_secure), .opt_q(opt_q), .user_rdata(user_rdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .req_ready(req_ready),
    .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_erase(mem_erase),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opt_load(opt_load),
    .erase_commit(erase_commit), .user_we(user_we),
    .sec_rd_hit(sec_rd_hit), .refused(refused)
  );
endmodule

// File: rtl/pgate_chk.sv
module pgate_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          resp_done,
  input logic          resp_err,
  input logic [7:0]    resp_rdata,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_erase,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    cfg_osc_mode,
  input logic          cfg_wdog_en,
  input logic          cfg_halt_en,
  input logic          cfg_secure,
  input logic          opt_load,
  input logic          erase_commit,
  input logic          sec_rd_hit,
  input logic          refused
);
  p_err_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_done);

  p_refuse_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> (resp_err && resp_done));

  p_secure_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rd_hit |=> (resp_done && resp_rdata == 8'hFF && !mem_req));

  p_no_mem_secure_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_erase) |-> !cfg_secure);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_secure |=> cfg_secure);

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_load && !erase_commit) |=>
      ($stable(cfg_osc_mode) && $stable(cfg_wdog_en) && $stable(cfg_halt_en)));

  p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind prog_access_gate pgate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .resp_done(resp_done), .resp_err(resp_err),
  .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_erase(mem_erase), .mem_addr(mem_addr), .cfg_osc_mode(cfg_osc_mode),
  .cfg_wdog_en(cfg_wdog_en), .cfg_halt_en(cfg_halt_en),
  .cfg_secure(cfg_secure), .opt_load(opt_load), .erase_commit(erase_commit),
  .sec_rd_hit(sec_rd_hit), .refused(refused)
);

// File: tb/prog_access_gate_test.sv
module prog_access_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_target = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, resp_done, resp_err;
  logic [7:0] resp_rdata;
  logic mem_req, mem_we, mem_erase;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_ack;
  logic [7:0] mem_rdata;
  logic [1:0] cfg_osc_mode;
  logic cfg_wdog_en, cfg_halt_en, cfg_secure;

  int n_vec = 0, n_bad = 0;
  int mem_lat = 0, lat_cnt = 0;
  bit finished = 0;

  // behavioural memory array (responder)
  logic [7:0] arr [DEPTH];
  // reference model
  int ref_prog [DEPTH];
  int ref_user [8];
  int ref_opt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_access_gate #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_target(req_target), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .resp_done(resp_done), .resp_err(resp_err),
    .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_erase(mem_erase), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cfg_osc_mode(cfg_osc_mode),
    .cfg_wdog_en(cfg_wdog_en), .cfg_halt_en(cfg_halt_en),
    .cfg_secure(cfg_secure)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; lat_cnt <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat_cnt == mem_lat) begin
        mem_ack <= 1'b1; lat_cnt <= 0;
        if (mem_erase) begin
          for (int i = 0; i < DEPTH; i++) arr[i] <= 8'h00;
        end else if (mem_we) arr[mem_addr] <= mem_wdata;
        else mem_rdata <= arr[mem_addr];
      end else lat_cnt <= lat_cnt + 1;
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input int got, input int exp, input string req, input string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_cfg(input string req);
    chk(cfg_osc_mode, (ref_opt >> 3) & 3, "R8", {req, " osc mode"});
    chk(cfg_wdog_en, ((ref_opt >> 2) & 1) ? 0 : 1, "R9", {req, " watchdog"});
    chk(cfg_halt_en, (ref_opt & 1) ? 0 : 1, "R9", {req, " halt"});
    chk(cfg_secure, (ref_opt >> 5) & 1, "R7", {req, " secure"});
  endtask

  // tgt: 0 prog, 1 option, 2 user, 3 erase
  task automatic xact(input bit wr, input int tgt, input int addr, input int wd,
                      input int lat, input string req);
    bit sec, to_mem, exp_err;
    int exp_rd, due;
    sec = ((ref_opt >> 5) & 1) != 0;
    to_mem = 0; exp_err = 0; exp_rd = 0;
    case (tgt)
      0: if (sec) begin exp_err = wr; exp_rd = wr ? 0 : 255; end
         else begin
           to_mem = 1;
           if (wr) ref_prog[addr] = wd; else exp_rd = ref_prog[addr];
         end
      1: if (wr) begin if (sec) exp_err = 1; else ref_opt = wd; end
         else exp_rd = ref_opt;
      2: if (wr) ref_user[addr % 8] = wd; else exp_rd = ref_user[addr % 8];
      default: begin
        to_mem = 1;
        for (int i = 0; i < DEPTH; i++) ref_prog[i] = 0;
        ref_opt = ref_opt & 32'h20;
      end
    endcase
    due = to_mem ? 2 + lat : 0;
    mem_lat = lat;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_target = tgt[1:0];
    req_addr = addr[AW-1:0]; req_wdata = wd[7:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k <= due; k++) begin
      if (k > 0) @(negedge clk);
      chk(resp_done, (k == due) ? 1 : 0, req, "done timing");
      chk(resp_err, (k == due) ? exp_err : 0, exp_err ? "R4" : "R11", "error flag");
      chk(mem_req, (to_mem && k < due) ? 1 : 0, to_mem ? "R2" : "R3", "mem_req");
    end
    chk(resp_rdata, exp_rd, req, "read data");
    chk_cfg(req);
    @(negedge clk);
    chk(resp_done, 0, "R11", "done one cycle");
    chk(resp_err, 0, "R4", "error one cycle");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin arr[i] = 8'h00; ref_prog[i] = 0; end
    for (int i = 0; i < 8; i++) ref_user[i] = 0;
    repeat (3) @(negedge clk);
    chk(req_ready, 1'bx === 1'b0 ? 0 : req_ready, "R1", "ready pre");
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, 1, "R1", "ready after reset");
    chk(resp_done, 0, "R1", "done after reset");
    chk(resp_err, 0, "R1", "err after reset");
    chk(mem_req, 0, "R1", "mem_req after reset");
    chk_cfg("R1");

    xact(0, 1, 0, 0, 0, "R5");
    xact(1, 0, 5, 8'hA5, 0, "R2");
    xact(1, 0, DEPTH - 1, 8'h3C, 3, "R2");
    xact(0, 0, 5, 0, 1, "R2");
    xact(0, 0, DEPTH - 1, 0, 0, "R2");
    xact(0, 0, 7, 0, 2, "R2");
    for (int i = 0; i < 8; i++) xact(1, 2, i, 8'h10 + i * 7, 0, "R6");
    xact(0, 2, 10'h3F9, 0, 0, "R6");
    xact(0, 2, 6, 0, 0, "R6");
    for (int v = 0; v < 4; v++) xact(1, 1, 0, v << 3, 0, "R8");
    xact(1, 1, 0, 8'h05, 0, "R9");
    xact(1, 1, 0, 8'h1C, 0, "R9");
    xact(0, 1, 0, 0, 0, "R5");
    xact(3, 3, 0, 0, 1, "R7");
    xact(0, 0, 5, 0, 0, "R7");
    xact(0, 0, DEPTH - 1, 0, 4, "R7");
    xact(1, 0, 9, 8'h77, 0, "R2");
    xact(1, 1, 0, 8'h2B, 0, "R7");
    xact(0, 0, 9, 0, 0, "R3");
    xact(0, 0, 5, 0, 0, "R3");
    xact(1, 0, 9, 8'h11, 0, "R4");
    xact(1, 1, 0, 8'h00, 0, "R4");
    xact(1, 1, 0, 8'h18, 0, "R10");
    xact(0, 1, 0, 0, 0, "R5");
    xact(1, 2, 3, 8'hE1, 0, "R6");
    xact(0, 2, 3, 0, 0, "R6");
    xact(1, 3, 0, 0, 2, "R7");
    xact(0, 1, 0, 0, 0, "R7");
    xact(1, 1, 0, 8'h00, 0, "R7");
    xact(0, 0, 9, 0, 0, "R3");
    repeat (3) @(negedge clk);
    chk(resp_done, 0, "R10", "idle done");
    chk_cfg("R10");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule